// File: doc/BRIEF.md
# Speculative Load Address Tracker

This block tracks loads that a compiler has hoisted above stores that might write the same memory. When such an early load issues, it records the load's destination register and memory address in a small fully associative table. Each executed store searches every live entry, and any entry whose address falls in the same 8-byte word as the store is invalidated.

Before the loaded value is used, a later instruction checks the table by register number. When a live entry is found, the value may be used and the entry is released. When none is found, the block tells the pipeline which repair to make. A reload-type check asks for the load to be issued again. A recovery-type check asks for a branch to repair code. The block does not touch the cache and does not perform the reload or the branch.

All three input ports are single-cycle strobes with no back-pressure: an allocate, a store snoop and a check can all arrive in the same cycle, and every one is accepted in that cycle. The check response is a registered strobe with no ready. The pipeline must sample it in the cycle it is presented.

Top module: `spec_ld_tracker`

## Requirements
- R1: After reset the table holds no live entry, so any check misses.
- R2: After an allocate for register R, a check for R with no intervening disturbance reports a hit (resp_hit=1, resp_reload=0, resp_recover=0).
- R3: A check that hits releases the entry, so a second check for the same register misses.
- R4: A store whose address matches a live entry's address in bits [63:3] invalidates that entry, whatever the low 3 bits are. A store to a different 8-byte word leaves the entry live.
- R5: On a miss, check kind 0 gives resp_reload=1 and resp_recover=0. Check kind 1 gives resp_recover=1 and resp_reload=0. Exactly one of resp_hit, resp_reload and resp_recover is high with each response.
- R6: An allocate for a register that already has a live entry overwrites that entry. After that, only the new address is snooped.
- R7: The table holds 16 entries. An allocate for a new register while all 16 are live evicts the entry allocated least recently, and the other 15 stay live.
- R8: A store and a check in the same cycle that hit the same live entry give a miss. The store takes precedence.
- R9: A check and an allocate for the same register in the same cycle: the check sees the table as it was before that cycle, and the newly allocated entry is live afterwards.
- R10: resp_valid is high exactly in the cycle after a cycle with chk_valid high. When resp_valid is low, all three outcome flags are low.
- R11: A store in the same cycle as an allocate does not invalidate the entry being allocated, even when the addresses match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Advanced load issues this cycle |
| alloc_reg | input | 7 | Destination register of the advanced load |
| alloc_addr | input | 64 | Byte address accessed by the advanced load |
| st_valid | input | 1 | Store executes this cycle |
| st_addr | input | 64 | Byte address written by the store |
| chk_valid | input | 1 | Check request this cycle |
| chk_reg | input | 7 | Register being checked |
| chk_kind | input | 1 | 0: reload on miss, 1: recovery branch on miss |
| resp_valid | output | 1 | Check response strobe |
| resp_hit | output | 1 | Entry was live; the value may be used |
| resp_reload | output | 1 | Miss on a reload-type check |
| resp_recover | output | 1 | Miss on a recovery-type check |

## Verification
Allocates and store snoops change the table at the clock edge that samples them, so a check driven in the next cycle already sees their effect. A check's response appears exactly one edge after the check is sampled. The bench drives each stimulus step half a period before an edge and reads the response half a period after the following edge. Each response is therefore compared against the step that caused it. In steps without a check the bench expects resp_valid to be low. The same-cycle cases (store with check, allocate with check, allocate with store) are written as single steps, so the precedence rules are checked in the exact cycle they apply.

// File: rtl/slt_pkg.sv
package slt_pkg;
  typedef enum logic {
    CHK_RELOAD  = 1'b0,
    CHK_RECOVER = 1'b1
  } chk_kind_e;
endpackage

// File: rtl/slt_entry.sv
module slt_entry #(
  parameter int REG_W    = 7,
  parameter int ADDR_W   = 64,
  parameter int OFS_BITS = 3,
  parameter int IDX_W    = 4,
  parameter int RST_RANK = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_reg,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              touch_en,
  input  logic [IDX_W-1:0]  touch_rank,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              clr,
  input  logic [REG_W-1:0]  chk_reg,
  output logic              live,
  output logic [IDX_W-1:0]  rank,
  output logic              alloc_match,
  output logic              chk_match,
  output logic              snoop_hit
);
  localparam logic [ADDR_W-1:0] WORD_MASK = {{(ADDR_W-OFS_BITS){1'b1}}, {OFS_BITS{1'b0}}};

  logic [REG_W-1:0]  reg_q;
  logic [ADDR_W-1:0] addr_q;

  assign alloc_match = live && (reg_q == wr_reg);
  assign chk_match   = live && (reg_q == chk_reg);
  assign snoop_hit   = live && st_valid && (((addr_q ^ st_addr) & WORD_MASK) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live   <= 1'b0;
      reg_q  <= '0;
      addr_q <= '0;
      rank   <= IDX_W'(RST_RANK);
    end else begin
      if (wr_en) begin
        live   <= 1'b1;
        reg_q  <= wr_reg;
        addr_q <= wr_addr;
      end else if (snoop_hit || clr) begin
        live <= 1'b0;
      end
      if (touch_en) begin
        if (wr_en)
          rank <= '0;
        else if (rank < touch_rank)
          rank <= rank + 1'b1;
      end
    end
  end
endmodule

// File: rtl/slt_picker.sv
module slt_picker #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic [ENTRIES-1:0]       live_v,
  input  logic [ENTRIES-1:0]       same_reg_v,
  input  logic [ENTRIES*IDX_W-1:0] rank_flat,
  output logic [IDX_W-1:0]         pick
);
  logic found_same, found_free;
  logic [IDX_W-1:0] same_idx, free_idx, old_idx;

  always_comb begin
    found_same = 1'b0;
    found_free = 1'b0;
    same_idx   = '0;
    free_idx   = '0;
    old_idx    = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (same_reg_v[i] && !found_same) begin
        found_same = 1'b1;
        same_idx   = IDX_W'(i);
      end
      if (!live_v[i] && !found_free) begin
        found_free = 1'b1;
        free_idx   = IDX_W'(i);
      end
      if (rank_flat[i*IDX_W +: IDX_W] == IDX_W'(ENTRIES-1))
        old_idx = IDX_W'(i);
    end
    if (found_same)
      pick = same_idx;
    else if (found_free)
      pick = free_idx;
    else
      pick = old_idx;
  end
endmodule

// File: rtl/spec_ld_tracker.sv
module spec_ld_tracker #(
  parameter int ENTRIES  = 16,
  parameter int REG_W    = 7,
  parameter int ADDR_W   = 64,
  parameter int OFS_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_kind,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_reload,
  output logic              resp_recover
);
  import slt_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]       live_v, same_reg_v, chk_v, snoop_v, wr_v;
  logic [ENTRIES*IDX_W-1:0] rank_flat;
  logic [IDX_W-1:0]         pick;
  logic [IDX_W-1:0]         touch_rank;
  logic                     hit_now;
  chk_kind_e                kind;

  slt_picker #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) picker_i (
    .live_v    (live_v),
    .same_reg_v(same_reg_v),
    .rank_flat (rank_flat),
    .pick      (pick)
  );

  assign touch_rank = rank_flat[pick*IDX_W +: IDX_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign wr_v[g] = alloc_valid && (pick == IDX_W'(g));
    slt_entry #(
      .REG_W(REG_W), .ADDR_W(ADDR_W), .OFS_BITS(OFS_BITS),
      .IDX_W(IDX_W), .RST_RANK(g)
    ) ent_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_v[g]),
      .wr_reg     (alloc_reg),
      .wr_addr    (alloc_addr),
      .touch_en   (alloc_valid),
      .touch_rank (touch_rank),
      .st_valid   (st_valid),
      .st_addr    (st_addr),
      .clr        (chk_valid && chk_v[g]),
      .chk_reg    (chk_reg),
      .live       (live_v[g]),
      .rank       (rank_flat[g*IDX_W +: IDX_W]),
      .alloc_match(same_reg_v[g]),
      .chk_match  (chk_v[g]),
      .snoop_hit  (snoop_v[g])
    );
  end

  assign hit_now = |(chk_v & ~snoop_v);
  assign kind    = chk_kind_e'(chk_kind);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      resp_hit     <= 1'b0;
      resp_reload  <= 1'b0;
      resp_recover <= 1'b0;
    end else begin
      resp_valid   <= chk_valid;
      resp_hit     <= chk_valid && hit_now;
      resp_reload  <= chk_valid && !hit_now && (kind == CHK_RELOAD);
      resp_recover <= chk_valid && !hit_now && (kind == CHK_RECOVER);
    end
  end
endmodule

// File: rtl/slt_checker.sv
module slt_checker (
  input logic clk,
  input logic rst_n,
  input logic chk_valid,
  input logic chk_kind,
  input logic resp_valid,
  input logic resp_hit,
  input logic resp_reload,
  input logic resp_recover
);
  // R10
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> resp_valid);

  // R10
  no_stray_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !resp_valid);

  // R10
  quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> !(resp_hit || resp_reload || resp_recover));

  // R5
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($countones({resp_hit, resp_reload, resp_recover}) == 1));

  // R5
  miss_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> (resp_hit || (resp_recover == $past(chk_kind))));
endmodule

bind spec_ld_tracker slt_checker slt_checker_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .chk_valid   (chk_valid),
  .chk_kind    (chk_kind),
  .resp_valid  (resp_valid),
  .resp_hit    (resp_hit),
  .resp_reload (resp_reload),
  .resp_recover(resp_recover)
);

// File: tb/spec_ld_tracker_tb.sv
`timescale 1ns/1ps
module spec_ld_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [6:0]  alloc_reg = '0;
  logic [63:0] alloc_addr = '0;
  logic        st_valid = 1'b0;
  logic [63:0] st_addr = '0;
  logic        chk_valid = 1'b0;
  logic [6:0]  chk_reg = '0;
  logic        chk_kind = 1'b0;
  logic        resp_valid, resp_hit, resp_reload, resp_recover;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spec_ld_tracker dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_reg(alloc_reg), .alloc_addr(alloc_addr),
    .st_valid(st_valid), .st_addr(st_addr),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_kind(chk_kind),
    .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_reload(resp_reload), .resp_recover(resp_recover)
  );

  // ex: 0 no response, 1 hit, 2 reload, 3 recover
  typedef struct packed {
    logic        a;
    logic [6:0]  ar;
    logic [15:0] aa;
    logic        s;
    logic [15:0] sa;
    logic        c;
    logic [6:0]  cr;
    logic        ck;
    logic [1:0]  ex;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 7'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 7'd5,  1'b0, 2'd2, 4'd1},  // R1 empty
    '{1'b1, 7'd5,  16'h0100, 1'b0, 16'h0000, 1'b0, 7'd0,  1'b0, 2'd0, 4'd10},
    '{1'b0, 7'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 7'd5,  1'b0, 2'd1, 4'd2},  // R2
    '{1'b0, 7'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 7'd5,  1'b1, 2'd3, 4'd3},  // R3 released
    '{1'b1, 7'd6,  16'h0200, 1'b0, 16'h0000, 1'b0, 7'd0,  1'b0, 2'd0, 4'd10},
    '{1'b0, 7'd0,  16'h0000, 1'b1, 16'h0207, 1'b0, 7'd0,  1'b0, 2'd0, 4'd10},
    '{1'b0, 7'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 7'd6,  1'b0, 2'd2, 4'd4},  // R4 same word
    '{1'b1, 7'd7,  16'h0300, 1'b0, 16'h0000, 1'b0, 7'd0,  1'b0, 2'd0, 4'd10},
    '{1'b0, 7'd0,  16'h0000, 1'b1, 16'h0308, 1'b0, 7'd0,  1'b0, 2'd0, 4'd10},
    '{1'b0, 7'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 7'd7,  1'b1, 2'd1, 4'd4},  // R4 other word
    '{1'b1, 7'd8,  16'h0400, 1'b0, 16'h0000, 1'b0, 7'd0,  1'b0, 2'd0, 4'd10},
    '{1'b1, 7'd8,  16'h0500, 1'b0, 16'h0000, 1'b0, 7'd0,  1'b0, 2'd0, 4'd10},
    '{1'b0, 7'd0,  16'h0000, 1'b1, 16'h0400, 1'b0, 7'd0,  1'b0, 2'd0, 4'd10},
    '{1'b0, 7'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 7'd8,  1'b0, 2'd1, 4'd6},  // R6
    '{1'b1, 7'd9,  16'h0600, 1'b0, 16'h0000, 1'b0, 7'd0,  1'b0, 2'd0, 4'd10},
    '{1'b0, 7'd0,  16'h0000, 1'b1, 16'h0600, 1'b1, 7'd9,  1'b0, 2'd2, 4'd8},  // R8
    '{1'b1, 7'd10, 16'h0700, 1'b0, 16'h0000, 1'b0, 7'd0,  1'b0, 2'd0, 4'd10},
    '{1'b1, 7'd10, 16'h0710, 1'b0, 16'h0000, 1'b1, 7'd10, 1'b1, 2'd1, 4'd9},  // R9 old view
    '{1'b0, 7'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 7'd10, 1'b0, 2'd1, 4'd9},  // R9 new live
    '{1'b1, 7'd11, 16'h0800, 1'b1, 16'h0800, 1'b0, 7'd0,  1'b0, 2'd0, 4'd10},
    '{1'b0, 7'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 7'd11, 1'b1, 2'd1, 4'd11}  // R11
  };

  task automatic expect_resp(input logic [1:0] ex, input int rq);
    logic [3:0] got, want;
    got  = {resp_valid, resp_hit, resp_reload, resp_recover};
    want = {ex != 2'd0, ex == 2'd1, ex == 2'd2, ex == 2'd3};
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL R%0d: {valid,hit,reload,recover} actual %b expected %b", rq, got, want);
    end
  endtask

  task automatic idle();
    alloc_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0;
  endtask

  // Drive at a falling edge; the response is read one full period later.
  task automatic step(input logic a, input logic [6:0] ar, input logic [15:0] aa,
                      input logic s, input logic [15:0] sa,
                      input logic c, input logic [6:0] cr, input logic ck,
                      input logic [1:0] ex, input int rq);
    alloc_valid = a; alloc_reg = ar; alloc_addr = {48'd0, aa};
    st_valid = s; st_addr = {48'd0, sa};
    chk_valid = c; chk_reg = cr; chk_kind = ck;
    @(negedge clk);
    idle();
    expect_resp(ex, rq);
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // R1 reset state: no response strobe
    expect_resp(2'd0, 1);
    for (int i = 0; i < NV; i++)
      step(VECS[i].a, VECS[i].ar, VECS[i].aa, VECS[i].s, VECS[i].sa,
           VECS[i].c, VECS[i].cr, VECS[i].ck, VECS[i].ex, int'(VECS[i].rq));

    // R7 fill 16 entries, the 17th evicts the least recent (reg 20)
    do_reset();
    for (int r = 20; r < 36; r++)
      step(1'b1, 7'(r), 16'(r * 64), 1'b0, 16'h0, 1'b0, 7'd0, 1'b0, 2'd0, 7);
    step(1'b1, 7'd36, 16'h4000, 1'b0, 16'h0, 1'b0, 7'd0, 1'b0, 2'd0, 7);
    step(1'b0, 7'd0, 16'h0, 1'b0, 16'h0, 1'b1, 7'd20, 1'b0, 2'd2, 7);
    for (int r = 21; r < 37; r++)
      step(1'b0, 7'd0, 16'h0, 1'b0, 16'h0, 1'b1, 7'(r), 1'b1, 2'd1, 7);

    // R5 recovery miss after reset, R1 on an unused register
    do_reset();
    step(1'b0, 7'd0, 16'h0, 1'b0, 16'h0, 1'b1, 7'd127, 1'b1, 2'd3, 5);
    step(1'b0, 7'd0, 16'h0, 1'b0, 16'h0, 1'b1, 7'd0, 1'b0, 2'd2, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    #2;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10: watchdog actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule